// File: doc/BRIEF.md
# Codirectional 64 kbit/s Line Code Encoder

This block turns a serial 64 kbit/s bit stream into the three-level codirectional line code, presented as two unipolar drive signals (positive mark, negative mark) for an external line driver. Each data bit is expanded into a block of four unit intervals. A one and a zero use two distinct four-interval patterns. Successive blocks take alternating polarity, so the line carries no DC. The eighth bit of every octet breaks that alternation on purpose, which lets the far end recover octet timing from the line alone.

The block runs on a fast system clock and advances one unit interval on each cycle in which the unit-interval enable (four times the bit rate) is high. The data bit and the octet marker are taken on the enable that opens a new block. The marker restarts the octet count. Without it, the count runs freely in eights from reset.

Top module: `codir_line_enc`

## Requirements
- R1: While reset is asserted, and after its release until the first unit-interval enable, both `line_pos` and `line_neg` are 0.
- R2: A data bit of 1 is sent as the interval pattern mark, mark, space, space (pattern 1100, first interval on the left). Every mark in it has the polarity of its block.
- R3: A data bit of 0 is sent as the interval pattern mark, space, mark, space (pattern 1010). Every mark in it has the polarity of its block.
- R4: `data_in` and `octet_mark` are sampled only on the enable that opens a block, which is every fourth enable counted from reset. Their values on the other three enables have no effect.
- R5: Successive blocks alternate in polarity. The first block after reset is positive. All marks inside one block share its polarity.
- R6: The block that carries the eighth bit of an octet repeats the polarity of the block before it. The next block alternates relative to that violation block.
- R7: A bit sampled with `octet_mark` high is bit 1 of a new octet. The seventh bit after it is therefore the violating bit.
- R8: Without markers, the octet count runs freely. The first bit after reset is bit 1, and every eighth bit violates.
- R9: `line_pos` and `line_neg` are never high in the same cycle.
- R10: The outputs change only at a clock edge where `ui_en` was high. Otherwise they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ui_en | input | 1 | Unit-interval enable, one cycle per interval (4x bit rate) |
| data_in | input | 1 | Data bit, sampled on a block-opening enable |
| octet_mark | input | 1 | High with the bit that is first in an octet |
| line_pos | output | 1 | Positive mark drive for the current interval |
| line_neg | output | 1 | Negative mark drive for the current interval |

## Verification
The assertions assume three things. `ui_en` is a single-cycle strobe. The first enable after reset opens a block. The configured patterns both begin with a mark. The stimulus keeps within these assumptions: it drives the enable as isolated pulses or as back-to-back runs, with idle gaps of varying length, and it never moves the block phase except through reset. Random values are driven on `data_in` and `octet_mark` during the three enables that do not open a block, and during idle cycles, so any sampling outside the block opening shows up at the line outputs.

// File: rtl/cle_pkg.sv
package cle_pkg;
   typedef enum logic {
      POL_NEG = 1'b0,
      POL_POS = 1'b1
   } pol_t;

   // default interval patterns, leftmost bit is the first interval on the line
   localparam logic [3:0] CLE_ONE_BLK  = 4'b1100;
   localparam logic [3:0] CLE_ZERO_BLK = 4'b1010;

   function automatic pol_t pol_flip(input pol_t p);
      return (p == POL_POS) ? POL_NEG : POL_POS;
   endfunction
endpackage

// File: rtl/cle_ui_seq.sv
module cle_ui_seq #(
   parameter int UI_PER_BIT = 4,
   localparam int IDX_W = (UI_PER_BIT > 1) ? $clog2(UI_PER_BIT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ui_en,
   output logic [IDX_W-1:0] ui_idx,
   output logic             blk_start
);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(UI_PER_BIT - 1);

   assign blk_start = ui_en && (ui_idx == '0);

   generate
      if ((1 << IDX_W) == UI_PER_BIT) begin : g_wrap_free
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     ui_idx <= '0;
            else if (ui_en) ui_idx <= ui_idx + 1'b1;
         end
      end else begin : g_wrap_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     ui_idx <= '0;
            else if (ui_en) ui_idx <= (ui_idx == IDX_LAST) ? '0 : ui_idx + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/cle_octet_ctr.sv
module cle_octet_ctr #(
   parameter int OCTET_BITS = 8,
   localparam int CNT_W = (OCTET_BITS > 1) ? $clog2(OCTET_BITS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             restart,
   output logic             viol,
   output logic [CNT_W-1:0] oct_cnt
);
   localparam logic [CNT_W-1:0] POS_LAST = CNT_W'(OCTET_BITS - 1);

   logic [CNT_W-1:0] pos_now;

   assign pos_now = restart ? '0 : oct_cnt;
   assign viol    = (pos_now == POS_LAST);

   generate
      if ((1 << CNT_W) == OCTET_BITS) begin : g_wrap_free
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    oct_cnt <= '0;
            else if (take) oct_cnt <= pos_now + 1'b1;
         end
      end else begin : g_wrap_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    oct_cnt <= '0;
            else if (take) oct_cnt <= viol ? '0 : pos_now + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/cle_polarity.sv
module cle_polarity
   import cle_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic viol,
   output pol_t pol_next
);
   pol_t last_pol;

   // a violating block keeps the previous polarity, others flip
   assign pol_next = viol ? last_pol : pol_flip(last_pol);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    last_pol <= POL_NEG;
      else if (take) last_pol <= pol_next;
   end
endmodule

// File: rtl/cle_shaper.sv
module cle_shaper
   import cle_pkg::*;
#(
   parameter int UI_PER_BIT = 4,
   parameter logic [UI_PER_BIT-1:0] ONE_BLK  = CLE_ONE_BLK,
   parameter logic [UI_PER_BIT-1:0] ZERO_BLK = CLE_ZERO_BLK,
   localparam int IDX_W = (UI_PER_BIT > 1) ? $clog2(UI_PER_BIT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ui_en,
   input  logic             take,
   input  logic             data,
   input  pol_t             pol_in,
   input  logic [IDX_W-1:0] ui_idx,
   output pol_t             blk_pol_q,
   output logic             line_pos,
   output logic             line_neg
);
   localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(UI_PER_BIT - 1);

   logic [UI_PER_BIT-1:0] pat_q;
   logic [UI_PER_BIT-1:0] pat_now;
   pol_t                  pol_now;
   logic                  mark_now;

   assign pat_now  = take ? (data ? ONE_BLK : ZERO_BLK) : pat_q;
   assign pol_now  = take ? pol_in : blk_pol_q;
   assign mark_now = pat_now[IDX_TOP - ui_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pat_q     <= '0;
         blk_pol_q <= POL_NEG;
         line_pos  <= 1'b0;
         line_neg  <= 1'b0;
      end else if (ui_en) begin
         line_pos <= mark_now && (pol_now == POL_POS);
         line_neg <= mark_now && (pol_now == POL_NEG);
         if (take) begin
            pat_q     <= pat_now;
            blk_pol_q <= pol_now;
         end
      end
   end
endmodule

// File: rtl/codir_line_enc.sv
module codir_line_enc
   import cle_pkg::*;
#(
   parameter int UI_PER_BIT = 4,
   parameter int OCTET_BITS = 8,
   parameter logic [UI_PER_BIT-1:0] ONE_BLK  = CLE_ONE_BLK,
   parameter logic [UI_PER_BIT-1:0] ZERO_BLK = CLE_ZERO_BLK
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ui_en,
   input  logic data_in,
   input  logic octet_mark,
   output logic line_pos,
   output logic line_neg
);
   localparam int IDX_W = (UI_PER_BIT > 1) ? $clog2(UI_PER_BIT) : 1;
   localparam int CNT_W = (OCTET_BITS > 1) ? $clog2(OCTET_BITS) : 1;

   generate
      if (UI_PER_BIT < 2) begin : g_bad_ui
         $error("UI_PER_BIT must be at least 2");
      end
      if (OCTET_BITS < 2) begin : g_bad_oct
         $error("OCTET_BITS must be at least 2");
      end
      if (ONE_BLK == ZERO_BLK) begin : g_bad_same
         $error("ONE_BLK and ZERO_BLK must differ");
      end
      if (!ONE_BLK[UI_PER_BIT-1] || !ZERO_BLK[UI_PER_BIT-1]) begin : g_bad_lead
         $error("both patterns must open with a mark");
      end
   endgenerate

   logic [IDX_W-1:0] ui_idx;
   logic             blk_start;
   logic             viol;
   logic [CNT_W-1:0] oct_cnt;
   pol_t             pol_next;
   pol_t             blk_pol_q;

   cle_ui_seq #(.UI_PER_BIT(UI_PER_BIT)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ui_en     (ui_en),
      .ui_idx    (ui_idx),
      .blk_start (blk_start)
   );

   cle_octet_ctr #(.OCTET_BITS(OCTET_BITS)) u_oct (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (blk_start),
      .restart (octet_mark),
      .viol    (viol),
      .oct_cnt (oct_cnt)
   );

   cle_polarity u_pol (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (blk_start),
      .viol     (viol),
      .pol_next (pol_next)
   );

   cle_shaper #(
      .UI_PER_BIT (UI_PER_BIT),
      .ONE_BLK    (ONE_BLK),
      .ZERO_BLK   (ZERO_BLK)
   ) u_shp (
      .clk       (clk),
      .rst_n     (rst_n),
      .ui_en     (ui_en),
      .take      (blk_start),
      .data      (data_in),
      .pol_in    (pol_next),
      .ui_idx    (ui_idx),
      .blk_pol_q (blk_pol_q),
      .line_pos  (line_pos),
      .line_neg  (line_neg)
   );
endmodule

// File: rtl/cle_chk.sv
module cle_chk #(
   parameter int IDX_W = 2,
   parameter int CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ui_en,
   input logic             blk_start,
   input logic [IDX_W-1:0] ui_idx,
   input logic             blk_pol_q,
   input logic             octet_mark,
   input logic [CNT_W-1:0] oct_cnt,
   input logic             line_pos,
   input logic             line_neg
);
   // R9
   never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_pos && line_neg));

   // R10
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ui_en |=> $stable({line_pos, line_neg}));

   // R2 R3
   lead_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_start |=> (line_pos || line_neg));

   // R5
   inblk_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ui_en && ui_idx != '0 && blk_pol_q) |=> !line_neg);

   // R5
   inblk_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ui_en && ui_idx != '0 && !blk_pol_q) |=> !line_pos);

   // R7
   mark_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_start && octet_mark) |=> (oct_cnt == CNT_W'(1)));
endmodule

bind codir_line_enc cle_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ui_en      (ui_en),
   .blk_start  (blk_start),
   .ui_idx     (ui_idx),
   .blk_pol_q  (blk_pol_q),
   .octet_mark (octet_mark),
   .oct_cnt    (oct_cnt),
   .line_pos   (line_pos),
   .line_neg   (line_neg)
);

// File: tb/sim_codir_line_enc.sv
module sim_codir_line_enc;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ui_en = 1'b0;
   logic data_in = 1'b0;
   logic octet_mark = 1'b0;
   logic line_pos;
   logic line_neg;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   // behavioural reference state
   int m_phase = 0;
   int m_cnt = 0;
   int m_last = -1;
   int m_pol = 0;
   int m_marks[4];
   bit exp_pos = 1'b0;
   bit exp_neg = 1'b0;
   int cap[4];

   always #4 clk = ~clk;

   codir_line_enc u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .ui_en      (ui_en),
      .data_in    (data_in),
      .octet_mark (octet_mark),
      .line_pos   (line_pos),
      .line_neg   (line_neg)
   );

   function automatic int lvl_of(input logic p, input logic n);
      return p ? 1 : (n ? -1 : 0);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_step(input bit en, input bit d, input bit m);
      int idx;
      int lvl;
      if (en) begin
         if (m_phase == 0) begin
            idx = m ? 0 : m_cnt;
            m_pol = (idx == 7) ? m_last : -m_last;
            m_last = m_pol;
            m_cnt = (idx + 1) % 8;
            if (d) begin
               m_marks[0] = 1; m_marks[1] = 1; m_marks[2] = 0; m_marks[3] = 0;
            end else begin
               m_marks[0] = 1; m_marks[1] = 0; m_marks[2] = 1; m_marks[3] = 0;
            end
         end
         lvl = m_marks[m_phase] * m_pol;
         exp_pos = (lvl > 0);
         exp_neg = (lvl < 0);
         m_phase = (m_phase + 1) % 4;
      end
   endtask

   task automatic tick(input bit en, input bit d, input bit m, input string req);
      @(negedge clk);
      ui_en = en;
      data_in = d;
      octet_mark = m;
      @(posedge clk);
      model_step(en, d, m);
      #1;
      check((line_pos == exp_pos) && (line_neg == exp_neg), req,
            lvl_of(line_pos, line_neg), lvl_of(exp_pos, exp_neg));
      // R9
      check(!(line_pos && line_neg), "R9", int'({line_pos, line_neg}), 0);
   endtask

   task automatic send_bit(input bit d, input bit m, input int gap, input string req);
      for (int u = 0; u < 4; u++) begin
         if (u == 0) tick(1'b1, d, m, req);
         else        tick(1'b1, 1'($urandom % 2), 1'($urandom % 2), "R4");
         cap[u] = lvl_of(line_pos, line_neg);
         for (int g = 0; g < gap; g++)
            tick(1'b0, 1'($urandom % 2), 1'($urandom % 2), "R10");
      end
   endtask

   task automatic check_cap(input int a, input int b, input int c, input int e, input string req);
      check(cap[0] == a, req, cap[0], a);
      check(cap[1] == b, req, cap[1], b);
      check(cap[2] == c, req, cap[2], c);
      check(cap[3] == e, req, cap[3], e);
   endtask

   initial begin
      int p7;
      // R1 during reset
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         ui_en = 1'($urandom % 2);
         data_in = 1'($urandom % 2);
         #1;
         check(!line_pos && !line_neg, "R1", lvl_of(line_pos, line_neg), 0);
      end
      @(negedge clk);
      ui_en = 1'b0;
      rst_n = 1'b1;
      // R1 after release, no enable yet
      for (int i = 0; i < 3; i++) tick(1'b0, 1'($urandom % 2), 1'($urandom % 2), "R1");

      // R2: first block, a one, positive
      send_bit(1'b1, 1'b1, 0, "R2");
      check_cap(1, 1, 0, 0, "R2");
      // R3: a zero, negative
      send_bit(1'b0, 1'b0, 1, "R3");
      check_cap(-1, 0, -1, 0, "R3");
      // R5: bits 3..7 alternate
      for (int b = 3; b <= 7; b++) send_bit(1'b1, 1'b0, 2, "R5");
      check(cap[0] == 1, "R5", cap[0], 1);
      // R6: eighth bit repeats, ninth resumes alternation
      send_bit(1'b1, 1'b0, 0, "R6");
      check_cap(1, 1, 0, 0, "R6");
      send_bit(1'b1, 1'b0, 1, "R6");
      check_cap(-1, -1, 0, 0, "R6");

      // R8: free running count, random data, varied gaps
      for (int b = 0; b < 27; b++) send_bit(1'($urandom % 2), 1'b0, b % 3, "R8");

      // R7: marker restarts the octet mid-count
      send_bit(1'b0, 1'b1, 1, "R7");
      for (int b = 2; b <= 6; b++) send_bit(1'($urandom % 2), 1'b0, 0, "R7");
      send_bit(1'b1, 1'b0, 0, "R7");
      p7 = cap[0];
      send_bit(1'b0, 1'b0, 2, "R7");
      check(cap[0] == p7, "R7", cap[0], p7);
      send_bit(1'b1, 1'b0, 1, "R7");
      check(cap[0] == -p7, "R7", cap[0], -p7);

      // R4: extra random traffic with garbage on the non-opening enables
      for (int b = 0; b < 12; b++) send_bit(1'($urandom % 2), 1'($urandom % 4 == 0), b % 2, "R4");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule